// File: doc/BRIEF.md
# Event-Configurable Communication Timer

One programmable timer slice that paces a serial shift engine. It produces a timer output level, a shift clock and a trigger output, and raises a sticky status flag on every compare event. A counter loaded from a 16-bit compare value runs in one of three counting modes: a single 16-bit counter, a pair of 8-bit counters in baud mode, or a pair of 8-bit counters in PWM mode. Separate selectable conditions start the timer, stop it, reload it and make it count. These conditions are built from one pin of an 8-bit pin bus, from a trigger input, and from the enable and disable events of the preceding timer in a chain.

The slice emits its own enable and disable events combinationally, in the cycle in which they are decided. This lets a neighbouring slice follow it in the same cycle. Start-bit and stop-bit framing insert one extra bit period that raises no compare. Polarity inversion on the trigger and the pin, together with a pin drive configuration, adapts the slice to the line it drives. All configuration is taken as static inputs from a register file outside this block.

Top module: `comm_evt_timer`

## Requirements
- R1: While reset is asserted, the timer output, flag and pin drive enable are 0. With mode 0 (off) the timer never runs, its output stays 0 and no flag is raised.
- R2: Mode 3 (16-bit): on enable the counter loads the compare value and the output takes its enable level. Each decrement counts down. A decrement at zero reloads the counter, toggles the output and is a compare event. The output therefore toggles every compare+1 decrements.
- R3: Mode 1 (baud): the low byte of the compare value reloads a divider, and the output toggles each time the divider expires. The high byte counts those expiries. A compare event occurs on the expiry at which the high counter is zero, and that counter then reloads.
- R4: Mode 2 (PWM): the output is at its enable level for low byte+1 decrements, then at the other level for high byte+1 decrements. The compare event comes at the end of the first phase.
- R5: Enable condition codes when idle: 0 always, 1 previous timer's enable event, 2 trigger high, 3 trigger and pin high, 4 pin rising edge, 5 pin rising edge with trigger high, 6 trigger rising edge, 7 either trigger edge. The enable event output pulses in the deciding cycle, and the timer runs from the next cycle.
- R6: Disable condition codes when running: 0 never, 1 previous timer's disable event, 2 compare, 3 compare with trigger low, 4 either pin edge, 5 either pin edge with trigger high, 6 trigger falling edge, 7 never. The disable event output pulses in the deciding cycle, and the output is 0 from the next cycle.
- R7: Reload condition codes: 2 pin equals timer output, 3 trigger equals timer output, 4 pin rising edge, 6 trigger rising edge, 7 either trigger edge. Codes 0, 1 and 5 never reload. A reload restores the compare value and takes priority over a decrement in the same cycle.
- R8: Decrement source: 0 every clock with the shift clock equal to the timer output; 1 either trigger edge with the shift clock equal to the output; 2 either pin edge with the shift clock equal to the pin; 3 either trigger edge with the shift clock equal to the trigger.
- R9: Output select: bit 0 chooses the enable level (0 high, 1 low). Bit 1 set also forces that level on a reload; clear, a reload leaves the output alone.
- R10: A start bit (start enable) or a stop bit after a compare (stop field bit 0) makes the next compare-length period raise no compare. A stop bit on disable (stop field bit 1) defers any disable to the end of the current period.
- R11: Trigger invert and pin invert flip the sampled trigger and pin before all condition, edge and shift-clock decoding. Pin invert also flips the driven pin value.
- R12: Pin drive config: 0 input (drive enable 0), 1 open drain (drive 0 only while the driven value is 0), 2 drive while running, 3 always drive.
- R13: The status flag sets on each compare event and holds until the clear input is 1 in a cycle with no new compare. A compare wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Counting mode (0 off, 1 baud, 2 PWM, 3 16-bit) |
| en_cond | input | 3 | Enable condition code |
| dis_cond | input | 3 | Disable condition code |
| rst_cond | input | 3 | Reload condition code |
| dec_src | input | 2 | Decrement source and shift clock select |
| out_sel | input | 2 | Output level and reload behaviour |
| stop_cfg | input | 2 | Stop bit on compare (bit 0) and on disable (bit 1) |
| start_en | input | 1 | Start bit on enable |
| trig_inv | input | 1 | Trigger active low |
| pin_inv | input | 1 | Pin active low |
| pin_cfg | input | 2 | Pin drive configuration |
| pin_sel | input | 3 | Index of the pin used by this timer |
| cmp_val | input | 16 | Compare value (high byte, low byte) |
| pins_in | input | 8 | Pin bus levels |
| trig_in | input | 1 | Trigger input |
| prev_en_evt | input | 1 | Enable event of the previous timer |
| prev_dis_evt | input | 1 | Disable event of the previous timer |
| flag_clr | input | 1 | Write-one clear of the status flag |
| trig_out | output | 1 | Timer output, also used as trigger output |
| shift_clk | output | 1 | Shift clock for the shift engine |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin drive enable |
| flag | output | 1 | Sticky compare status flag |
| en_evt | output | 1 | Enable event for the next timer |
| dis_evt | output | 1 | Disable event for the next timer |

## Verification
The event outputs and the shift clock are combinational, so the bench reads them one time step after it drives the causing input, within the same cycle. Counter, output and flag results land on the next rising edge and are read at the following falling edge. Counted from reset release, the first enable is visible at the first falling edge, and in 16-bit mode with compare N the first toggle arrives at falling edge N+2. The vector table counts output toggles and flag cycles over 20 falling edges, so any shift by one cycle changes a count. The directed tests drive trigger and pin edges at falling edges and check a fixed number of falling edges later.

// File: rtl/comm_evt_timer.sv
module comm_evt_timer #(
  parameter int NPIN = 8,
  parameter int HALF = 8,
  localparam int SELW = $clog2(NPIN),
  localparam int CW = 2 * HALF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [2:0]      en_cond,
  input  logic [2:0]      dis_cond,
  input  logic [2:0]      rst_cond,
  input  logic [1:0]      dec_src,
  input  logic [1:0]      out_sel,
  input  logic [1:0]      stop_cfg,
  input  logic            start_en,
  input  logic            trig_inv,
  input  logic            pin_inv,
  input  logic [1:0]      pin_cfg,
  input  logic [SELW-1:0] pin_sel,
  input  logic [CW-1:0]   cmp_val,
  input  logic [NPIN-1:0] pins_in,
  input  logic            trig_in,
  input  logic            prev_en_evt,
  input  logic            prev_dis_evt,
  input  logic            flag_clr,
  output logic            trig_out,
  output logic            shift_clk,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            flag,
  output logic            en_evt,
  output logic            dis_evt
);

  logic run, tout, ph, gap, pend, pin_q, trg_q;
  logic [CW-1:0] cnt, cnt_d;
  logic ph_d, tog, raw;
  logic pin_s, trg_s, pin_rise, pin_edge, trg_rise, trg_fall, trg_edge;
  logic active, dec, en_ok, dis_ok, rs_ok;
  logic en_hit, rst_hit, tick, raw_hit, cmp_evt, dis_req, dis_now, drive;
  logic [HALF-1:0] lo, hi;

  assign pin_s    = pins_in[pin_sel] ^ pin_inv;
  assign trg_s    = trig_in ^ trig_inv;
  assign pin_rise = pin_s & ~pin_q;
  assign pin_edge = pin_s ^ pin_q;
  assign trg_rise = trg_s & ~trg_q;
  assign trg_fall = ~trg_s & trg_q;
  assign trg_edge = trg_s ^ trg_q;
  assign active   = mode != 2'd0;
  assign lo       = cnt[HALF-1:0];
  assign hi       = cnt[CW-1:HALF];

  always_comb begin
    case (dec_src)
      2'd0:    dec = 1'b1;
      2'd2:    dec = pin_edge;
      default: dec = trg_edge;
    endcase
    case (en_cond)
      3'd0:    en_ok = 1'b1;
      3'd1:    en_ok = prev_en_evt;
      3'd2:    en_ok = trg_s;
      3'd3:    en_ok = trg_s & pin_s;
      3'd4:    en_ok = pin_rise;
      3'd5:    en_ok = pin_rise & trg_s;
      3'd6:    en_ok = trg_rise;
      default: en_ok = trg_edge;
    endcase
    case (rst_cond)
      3'd2:    rs_ok = pin_s == tout;
      3'd3:    rs_ok = trg_s == tout;
      3'd4:    rs_ok = pin_rise;
      3'd6:    rs_ok = trg_rise;
      3'd7:    rs_ok = trg_edge;
      default: rs_ok = 1'b0;
    endcase
  end

  always_comb begin
    cnt_d = cnt;
    ph_d  = ph;
    tog   = 1'b0;
    raw   = 1'b0;
    case (mode)
      2'd1: begin
        if (lo == '0) begin
          cnt_d[HALF-1:0] = cmp_val[HALF-1:0];
          tog = 1'b1;
          if (hi == '0) begin
            raw = 1'b1;
            cnt_d[CW-1:HALF] = cmp_val[CW-1:HALF];
          end else begin
            cnt_d[CW-1:HALF] = hi - 1'b1;
          end
        end else begin
          cnt_d[HALF-1:0] = lo - 1'b1;
        end
      end
      2'd2: begin
        if (!ph) begin
          if (lo == '0) begin
            cnt_d[HALF-1:0] = cmp_val[HALF-1:0];
            tog  = 1'b1;
            raw  = 1'b1;
            ph_d = 1'b1;
          end else begin
            cnt_d[HALF-1:0] = lo - 1'b1;
          end
        end else begin
          if (hi == '0) begin
            cnt_d[CW-1:HALF] = cmp_val[CW-1:HALF];
            tog  = 1'b1;
            ph_d = 1'b0;
          end else begin
            cnt_d[CW-1:HALF] = hi - 1'b1;
          end
        end
      end
      2'd3: begin
        if (cnt == '0) begin
          cnt_d = cmp_val;
          tog   = 1'b1;
          raw   = 1'b1;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign en_hit  = active & ~run & en_ok;
  assign rst_hit = active & run & rs_ok;
  assign tick    = active & run & ~rst_hit & dec;
  assign raw_hit = tick & raw;
  assign cmp_evt = raw_hit & ~gap;

  always_comb begin
    case (dis_cond)
      3'd1:    dis_ok = prev_dis_evt;
      3'd2:    dis_ok = cmp_evt;
      3'd3:    dis_ok = cmp_evt & ~trg_s;
      3'd4:    dis_ok = pin_edge;
      3'd5:    dis_ok = pin_edge & trg_s;
      3'd6:    dis_ok = trg_fall;
      default: dis_ok = 1'b0;
    endcase
  end

  assign dis_req = active & run & dis_ok;
  assign dis_now = (dis_req & ~stop_cfg[1]) | (pend & raw_hit);
  assign en_evt  = en_hit;
  assign dis_evt = dis_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; tout <= 1'b0; ph <= 1'b0; gap <= 1'b0; pend <= 1'b0;
      cnt <= '0; pin_q <= 1'b0; trg_q <= 1'b0; flag <= 1'b0;
    end else begin
      pin_q <= pin_s;
      trg_q <= trg_s;
      if (cmp_evt) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (!active) begin
        run <= 1'b0; tout <= 1'b0; gap <= 1'b0; pend <= 1'b0;
      end else if (!run) begin
        if (en_hit) begin
          run  <= 1'b1;
          cnt  <= cmp_val;
          tout <= ~out_sel[0];
          ph   <= 1'b0;
          gap  <= start_en;
          pend <= 1'b0;
        end
      end else if (dis_now) begin
        run <= 1'b0; tout <= 1'b0; gap <= 1'b0; pend <= 1'b0;
      end else begin
        if (dis_req && stop_cfg[1]) pend <= 1'b1;
        if (rst_hit) begin
          cnt <= cmp_val;
          ph  <= 1'b0;
          if (out_sel[1]) tout <= ~out_sel[0];
        end else if (tick) begin
          cnt  <= cnt_d;
          ph   <= ph_d;
          tout <= tout ^ tog;
          if (raw) gap <= ~gap & stop_cfg[0];
        end
      end
    end
  end

  assign trig_out = tout;
  assign drive    = tout ^ pin_inv;
  assign pin_out  = (pin_cfg == 2'd1) ? 1'b0 : drive;

  always_comb begin
    case (dec_src)
      2'd2:    shift_clk = pin_s;
      2'd3:    shift_clk = trg_s;
      default: shift_clk = tout;
    endcase
    case (pin_cfg)
      2'd0:    pin_oe = 1'b0;
      2'd1:    pin_oe = ~drive;
      2'd2:    pin_oe = run;
      default: pin_oe = 1'b1;
    endcase
  end

  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |=> !run && !trig_out); // R1
  AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    en_evt |=> run); // R5
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_evt |=> !run && !trig_out); // R6
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit && !dis_now |=> cnt == $past(cmp_val)); // R7
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> flag); // R13
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R13

endmodule

// File: tb/comm_evt_timer_tb.sv
`timescale 1ns/1ps
module comm_evt_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = '0, dec_src = '0, out_sel = '0, stop_cfg = '0, pin_cfg = '0;
  logic [2:0] en_cond = '0, dis_cond = '0, rst_cond = '0, pin_sel = '0;
  logic start_en = 0, trig_inv = 0, pin_inv = 0, trig_in = 0;
  logic prev_en_evt = 0, prev_dis_evt = 0, flag_clr = 0;
  logic [15:0] cmp_val = '0;
  logic [7:0] pins_in = '0;
  logic trig_out, shift_clk, pin_out, pin_oe, flag, en_evt, dis_evt;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  comm_evt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .en_cond(en_cond), .dis_cond(dis_cond),
    .rst_cond(rst_cond), .dec_src(dec_src), .out_sel(out_sel), .stop_cfg(stop_cfg),
    .start_en(start_en), .trig_inv(trig_inv), .pin_inv(pin_inv), .pin_cfg(pin_cfg),
    .pin_sel(pin_sel), .cmp_val(cmp_val), .pins_in(pins_in), .trig_in(trig_in),
    .prev_en_evt(prev_en_evt), .prev_dis_evt(prev_dis_evt), .flag_clr(flag_clr),
    .trig_out(trig_out), .shift_clk(shift_clk), .pin_out(pin_out), .pin_oe(pin_oe),
    .flag(flag), .en_evt(en_evt), .dis_evt(dis_evt));

  typedef struct packed {
    logic [1:0] md; logic [2:0] en; logic [2:0] ds; logic [2:0] rs;
    logic [1:0] dc; logic [1:0] os; logic [1:0] sp; logic st;
    logic [15:0] cv; logic [7:0] tg; logic [7:0] fl; logic rn;
  } vec_t;

  localparam vec_t VT [0:10] = '{
    '{2'd3, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0003, 8'd5, 8'd4, 1'b1},
    '{2'd3, 3'd0, 3'd2, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0003, 8'd8, 8'd4, 1'b0},
    '{2'd1, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0102, 8'd7, 8'd3, 1'b1},
    '{2'd2, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0102, 8'd8, 8'd4, 1'b1},
    '{2'd3, 3'd0, 3'd0, 3'd0, 2'd0, 2'd1, 2'd0, 1'b0, 16'h0003, 8'd4, 8'd4, 1'b1},
    '{2'd3, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b1, 16'h0003, 8'd5, 8'd3, 1'b1},
    '{2'd3, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd1, 1'b0, 16'h0003, 8'd5, 8'd2, 1'b1},
    '{2'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0003, 8'd0, 8'd0, 1'b0},
    '{2'd3, 3'd0, 3'd2, 3'd0, 2'd0, 2'd0, 2'd2, 1'b0, 16'h0003, 8'd5, 8'd4, 1'b1},
    '{2'd3, 3'd0, 3'd0, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0003, 8'd2, 8'd1, 1'b1},
    '{2'd3, 3'd0, 3'd0, 3'd1, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0003, 8'd5, 8'd4, 1'b1}
  };
  string vreq [0:10] = '{"R2", "R6", "R3", "R4", "R9", "R10", "R10", "R1", "R10", "R7", "R7"};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic defaults();
    mode = 2'd3; en_cond = '0; dis_cond = '0; rst_cond = '0; dec_src = '0;
    out_sel = '0; stop_cfg = '0; start_en = 0; trig_inv = 0; pin_inv = 0;
    pin_cfg = 2'd2; pin_sel = '0; cmp_val = 16'd3; pins_in = '0; trig_in = 0;
    prev_en_evt = 0; prev_dis_evt = 0; flag_clr = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    defaults();
    repeat (2) @(negedge clk);
    chk("R1 reset out", trig_out, 0);
    chk("R1 reset flag", flag, 0);
    chk("R1 reset oe", pin_oe, 0);

    for (int v = 0; v <= 10; v++) begin
      int tg, fl;
      logic prev;
      rst_n = 1'b0;
      defaults();
      mode = VT[v].md; en_cond = VT[v].en; dis_cond = VT[v].ds; rst_cond = VT[v].rs;
      dec_src = VT[v].dc; out_sel = VT[v].os; stop_cfg = VT[v].sp; start_en = VT[v].st;
      cmp_val = VT[v].cv;
      restart();
      tg = 0; fl = 0; prev = 1'b0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (trig_out != prev) tg++;
        prev = trig_out;
        if (flag) fl++;
      end
      chk({vreq[v], " toggles"}, tg, int'(VT[v].tg));
      chk({vreq[v], " flags"}, fl, int'(VT[v].fl));
      chk({vreq[v], " running"}, pin_oe, int'(VT[v].rn));
    end

    // R5 pin rising enable, R6 trigger falling disable
    rst_n = 1'b0; defaults();
    cmp_val = 16'd100; en_cond = 3'd4; dis_cond = 3'd6; pin_sel = 3'd5; pin_cfg = 2'd3;
    restart();
    @(negedge clk);
    chk("R5 idle before edge", trig_out, 0);
    pins_in = 8'h20; #1;
    chk("R5 enable event", en_evt, 1);
    @(negedge clk);
    chk("R5 running", trig_out, 1);
    trig_in = 1'b1;
    @(negedge clk);
    chk("R6 rise ignored", trig_out, 1);
    trig_in = 1'b0; #1;
    chk("R6 disable event", dis_evt, 1);
    @(negedge clk);
    chk("R6 stopped", trig_out, 0);
    repeat (2) @(negedge clk);
    chk("R5 no re-enable", trig_out, 0);

    // R11 trigger polarity, R12 pin invert drive
    rst_n = 1'b0; defaults();
    cmp_val = 16'd100; en_cond = 3'd2; trig_inv = 1'b1; trig_in = 1'b1;
    pin_inv = 1'b1; pin_cfg = 2'd3;
    restart();
    repeat (2) @(negedge clk);
    chk("R11 inverted trigger idle", trig_out, 0);
    chk("R11 inverted pin drive", pin_out, 1);
    chk("R12 push-pull oe", pin_oe, 1);
    trig_in = 1'b0;
    @(negedge clk);
    chk("R11 enable on low trigger", trig_out, 1);
    chk("R11 pin drive low", pin_out, 0);

    // R12 open drain and input config
    rst_n = 1'b0; defaults();
    mode = 2'd0; pin_cfg = 2'd1;
    restart();
    @(negedge clk);
    chk("R12 open drain oe", pin_oe, 1);
    chk("R12 open drain value", pin_out, 0);
    pin_cfg = 2'd0; #1;
    chk("R12 input oe", pin_oe, 0);

    // R7 reload priority with R9 output forced, R13 sticky flag
    rst_n = 1'b0; defaults();
    rst_cond = 3'd6; out_sel = 2'd2; flag_clr = 1'b0;
    restart();
    repeat (4) @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk);
    chk("R7 reload beats expiry", trig_out, 1);
    chk("R7 no compare", flag, 0);
    repeat (3) @(negedge clk);
    chk("R9 level after reload", trig_out, 1);
    @(negedge clk);
    chk("R7 late expiry", trig_out, 0);
    chk("R13 flag set", flag, 1);
    @(negedge clk);
    chk("R13 flag held", flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    chk("R13 flag cleared", flag, 0);

    // R8 decrement on trigger edges, shift clock sources
    rst_n = 1'b0; defaults();
    cmp_val = 16'd1; dec_src = 2'd1;
    restart();
    repeat (3) @(negedge clk);
    chk("R8 no clock decrement", trig_out, 1);
    trig_in = 1'b1;
    @(negedge clk);
    chk("R8 first edge", trig_out, 1);
    trig_in = 1'b0;
    @(negedge clk);
    chk("R8 second edge expiry", trig_out, 0);
    chk("R8 shift clock is output", shift_clk, 0);
    dec_src = 2'd3; trig_in = 1'b1; #1;
    chk("R8 shift clock is trigger", shift_clk, 1);
    dec_src = 2'd2; #1;
    chk("R8 shift clock is pin low", shift_clk, 0);
    pins_in = 8'h01; #1;
    chk("R8 shift clock is pin high", shift_clk, 1);

    // R5 and R6 chained from the previous timer
    rst_n = 1'b0; defaults();
    cmp_val = 16'd100; en_cond = 3'd1; dis_cond = 3'd1;
    restart();
    @(negedge clk);
    chk("R5 chain idle", trig_out, 0);
    prev_en_evt = 1'b1;
    @(negedge clk);
    prev_en_evt = 1'b0;
    chk("R5 chained enable", trig_out, 1);
    prev_dis_evt = 1'b1;
    @(negedge clk);
    prev_dis_evt = 1'b0;
    chk("R6 chained disable", trig_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule